// File: doc/BRIEF.md
# Conversion Result Averager and Formatter

This block sits behind the digital filter of a sigma-delta converter. Each raw 24-bit result arrives with a channel tag and an overflow flag. Per channel, the block either passes every result through or forms a block average over 8, 16, 32 or 64 consecutive results of that channel. Each finished result then leaves in two forms. The first is a 32-bit register read value, shaped by the global resolution and alignment settings and by the channel's input-mode settings. The second is a packed transfer word that carries a channel tag and suits a DMA-style consumer.

Per channel, the configuration selects the averaging count, differential or single-ended input, the polarity of a single-ended input, and inversion of a negative single-ended result. A one-cycle conversion-end strobe marks every new output result. Both outputs hold their value until the next strobe.

Top module: `result_avg_fmt`

## Requirements
- R1: The per-channel averaging code selects the number of samples per result: 0 gives 1 (no averaging), 1 gives 8, 2 gives 16, 3 gives 32 and 4 gives 64.
- R2: `conv_end_o` is high for exactly one cycle, in the cycle after the clock edge that accepts the last sample of a result. With averaging off, every accepted sample produces a strobe. It is low at all other times.
- R3: The transfer word holds the 24-bit result in bits 23:0, the overflow flag in bit 24 and the channel number plus one in bits 27:25. Bits 31:28 are zero.
- R4: Bits 23:0 of the transfer word are the unformatted average. Resolution, alignment and inversion settings have no effect on them.
- R5: With 16-bit resolution, the read value carries bits 23:8 of the 24-bit result, and bits 7:0 are dropped.
- R6: A differential result is two's complement. With right alignment, the read value has its sign at bit 23 (24-bit) or bit 15 (16-bit), and every bit above the result is zero.
- R7: For a single-ended channel with negative polarity and inversion enabled, the read value is (2^res − 1) minus the non-inverted result. Inversion has no effect on any other channel.
- R8: With left alignment, the result's most significant bit sits at read bit 31, and the bits below the result are zero.
- R9: An averaged result is floor(sum / N). The sum is signed for differential channels and unsigned for single-ended channels.
- R10: The overflow flag of a result is the OR of the flags of all its samples.
- R11: A sample for a channel other than the one being accumulated discards the partial sum and starts a new average. Reset also discards a partial sum.
- R12: While reset is asserted and after it is released, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Raw sample present this cycle |
| sample_data_i | input | 24 | Raw conversion result |
| sample_ovf_i | input | 1 | Raw sample overflowed |
| sample_ch_i | input | 3 | Channel of the raw sample |
| avg_sel_i | input | NUM_CH x 3 | Averaging code per channel |
| single_ended_i | input | NUM_CH | 1 = single-ended input, 0 = differential |
| neg_pol_i | input | NUM_CH | Single-ended polarity, 1 = negative |
| invert_i | input | NUM_CH | Invert a negative single-ended result |
| res16_i | input | 1 | 1 = 16-bit resolution, 0 = 24-bit |
| left_align_i | input | 1 | 1 = left aligned read value |
| conv_end_o | output | 1 | Conversion-end strobe |
| read_data_o | output | 32 | Formatted register read value |
| read_ch_o | output | 3 | Channel of the current result |
| xfer_word_o | output | 32 | Packed transfer word |

## Verification
A wrong sample counter or a bad shift amount shows up at the end of the averaging window. The strobe then arrives too early or too late, or the average lands off by a power of two. Either fault is seen on the first result of the affected count. A partial sum that survives a channel switch or a reset shows up in the next strobe's value for the new channel. A lost overflow OR shows up in transfer bit 24 of that same result. Formatting faults appear in the same cycle as the strobe, because the read value and the transfer word come from one result, and the bench sweeps every count, input mode, resolution and alignment against arithmetic expectations.

// File: rtl/result_avg_fmt_pkg.sv
package result_avg_fmt_pkg;
  localparam int unsigned DATA_W   = 24;
  localparam int unsigned ACC_W    = 31;
  localparam int unsigned MAX_SHFT = 6;
  localparam int unsigned CNT_W    = MAX_SHFT + 1;
  localparam int unsigned CH_W     = 3;
  localparam int unsigned WORD_W   = 32;

  typedef enum logic [2:0] {
    AVG_OFF = 3'd0,
    AVG_8   = 3'd1,
    AVG_16  = 3'd2,
    AVG_32  = 3'd3,
    AVG_64  = 3'd4
  } avg_code_e;

  function automatic logic [2:0] avg_shift(input logic [2:0] code);
    unique case (code)
      AVG_8:   avg_shift = 3'd3;
      AVG_16:  avg_shift = 3'd4;
      AVG_32:  avg_shift = 3'd5;
      AVG_64:  avg_shift = 3'd6;
      default: avg_shift = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/result_avg_accum.sv
module result_avg_accum
  import result_avg_fmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ovf_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic              signed_i,
  input  logic [2:0]        shift_i,
  output logic              done_o,
  output logic [DATA_W-1:0] avg_o,
  output logic              ovf_o
);
  localparam int unsigned EXT_W = ACC_W - DATA_W;

  logic                    active_q;
  logic [CH_W-1:0]         ch_q;
  logic signed [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0]        cnt_q;
  logic                    ovf_q;

  logic                    fresh;
  logic signed [ACC_W-1:0] base_acc, ext, sum, shifted;
  logic [CNT_W-1:0]        base_cnt, nxt_cnt, target;
  logic                    nxt_ovf;

  always_comb begin
    fresh    = !active_q || (ch_i != ch_q);
    base_acc = fresh ? '0 : acc_q;
    base_cnt = fresh ? '0 : cnt_q;
    ext      = signed_i ? {{EXT_W{data_i[DATA_W-1]}}, data_i} : {{EXT_W{1'b0}}, data_i};
    sum      = base_acc + ext;
    nxt_cnt  = base_cnt + CNT_W'(1);
    target   = CNT_W'(1) << shift_i;
    nxt_ovf  = (!fresh && ovf_q) || ovf_i;
    shifted  = sum >>> shift_i;
    done_o   = valid_i && (nxt_cnt == target);
    avg_o    = shifted[DATA_W-1:0];
    ovf_o    = nxt_ovf;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      ch_q     <= '0;
      acc_q    <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else if (valid_i) begin
      active_q <= !done_o;
      ch_q     <= ch_i;
      acc_q    <= sum;
      cnt_q    <= nxt_cnt;
      ovf_q    <= nxt_ovf;
    end
  end
endmodule

// File: rtl/result_fmt.sv
module result_fmt
  import result_avg_fmt_pkg::*;
(
  input  logic [DATA_W-1:0] val_i,
  input  logic              single_ended_i,
  input  logic              neg_pol_i,
  input  logic              invert_i,
  input  logic              res16_i,
  input  logic              left_align_i,
  output logic [WORD_W-1:0] read_o
);
  localparam int unsigned R16_W = 16;
  localparam int unsigned DROP  = DATA_W - R16_W;

  logic [DATA_W-1:0] w;
  logic [R16_W-1:0]  w16;

  always_comb begin
    // flipping all 24 bits before truncation inverts at either resolution
    w   = (single_ended_i && neg_pol_i && invert_i) ? ~val_i : val_i;
    w16 = w[DATA_W-1:DROP];
    unique case ({res16_i, left_align_i})
      2'b00:   read_o = {{(WORD_W-DATA_W){1'b0}}, w};
      2'b01:   read_o = {w, {(WORD_W-DATA_W){1'b0}}};
      2'b10:   read_o = {{(WORD_W-R16_W){1'b0}}, w16};
      default: read_o = {w16, {(WORD_W-R16_W){1'b0}}};
    endcase
  end
endmodule

// File: rtl/result_avg_fmt.sv
module result_avg_fmt
  import result_avg_fmt_pkg::*;
#(
  parameter int unsigned NUM_CH = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sample_valid_i,
  input  logic [23:0]            sample_data_i,
  input  logic                   sample_ovf_i,
  input  logic [2:0]             sample_ch_i,
  input  logic [NUM_CH-1:0][2:0] avg_sel_i,
  input  logic [NUM_CH-1:0]      single_ended_i,
  input  logic [NUM_CH-1:0]      neg_pol_i,
  input  logic [NUM_CH-1:0]      invert_i,
  input  logic                   res16_i,
  input  logic                   left_align_i,
  output logic                   conv_end_o,
  output logic [31:0]            read_data_o,
  output logic [2:0]             read_ch_o,
  output logic [31:0]            xfer_word_o
);
  localparam int unsigned PAD_W = WORD_W - DATA_W - 1 - CH_W;

  logic [DATA_W-1:0] avg;
  logic              avg_ovf, done;
  logic [WORD_W-1:0] fmt_read;
  logic [CH_W-1:0]   tag;

  result_avg_accum u_accum (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (sample_valid_i),
    .data_i   (sample_data_i),
    .ovf_i    (sample_ovf_i),
    .ch_i     (sample_ch_i),
    .signed_i (!single_ended_i[sample_ch_i]),
    .shift_i  (avg_shift(avg_sel_i[sample_ch_i])),
    .done_o   (done),
    .avg_o    (avg),
    .ovf_o    (avg_ovf)
  );

  result_fmt u_fmt (
    .val_i          (avg),
    .single_ended_i (single_ended_i[sample_ch_i]),
    .neg_pol_i      (neg_pol_i[sample_ch_i]),
    .invert_i       (invert_i[sample_ch_i]),
    .res16_i        (res16_i),
    .left_align_i   (left_align_i),
    .read_o         (fmt_read)
  );

  assign tag = sample_ch_i + CH_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conv_end_o  <= 1'b0;
      read_data_o <= '0;
      read_ch_o   <= '0;
      xfer_word_o <= '0;
    end else begin
      conv_end_o <= done;
      if (done) begin
        read_data_o <= fmt_read;
        read_ch_o   <= sample_ch_i;
        xfer_word_o <= {{PAD_W{1'b0}}, tag, avg_ovf, avg};
      end
    end
  end
endmodule

// File: rtl/result_avg_fmt_chk.sv
module result_avg_fmt_chk #(
  parameter int unsigned NUM_CH = 5
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   sample_valid_i,
  input logic [23:0]            sample_data_i,
  input logic                   sample_ovf_i,
  input logic [2:0]             sample_ch_i,
  input logic [NUM_CH-1:0][2:0] avg_sel_i,
  input logic [NUM_CH-1:0]      single_ended_i,
  input logic [NUM_CH-1:0]      neg_pol_i,
  input logic [NUM_CH-1:0]      invert_i,
  input logic                   res16_i,
  input logic                   left_align_i,
  input logic                   conv_end_o,
  input logic [31:0]            read_data_o,
  input logic [2:0]             read_ch_o,
  input logic [31:0]            xfer_word_o
);
  AST_STROBE_NEEDS_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_end_o |-> $past(sample_valid_i)); // R2

  AST_PASS_THROUGH_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && avg_sel_i[sample_ch_i] == 3'd0) |=> conv_end_o); // R1

  AST_XFER_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_end_o |-> (xfer_word_o[27:25] == read_ch_o + 3'd1 && xfer_word_o[31:28] == 4'd0)); // R3

  AST_HOLD_BETWEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_end_o |-> ($stable(xfer_word_o) && $stable(read_data_o))); // R2

  AST_RIGHT24_TOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_end_o && !$past(left_align_i) && !$past(res16_i)) |-> read_data_o[31:24] == 8'd0); // R6

  AST_RIGHT16_TOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_end_o && !$past(left_align_i) && $past(res16_i)) |-> read_data_o[31:16] == 16'd0); // R5

  AST_LEFT_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_end_o && $past(left_align_i)) |-> read_data_o[7:0] == 8'd0); // R8
endmodule

bind result_avg_fmt result_avg_fmt_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/result_avg_fmt_bench.sv
module result_avg_fmt_bench;
  localparam int NUM_CH = 5;

  logic                   clk_i = 1'b0;
  logic                   rst_ni = 1'b0;
  logic                   sample_valid_i = 1'b0;
  logic [23:0]            sample_data_i = '0;
  logic                   sample_ovf_i = 1'b0;
  logic [2:0]             sample_ch_i = '0;
  logic [NUM_CH-1:0][2:0] avg_sel_i = '0;
  logic [NUM_CH-1:0]      single_ended_i = '0;
  logic [NUM_CH-1:0]      neg_pol_i = '0;
  logic [NUM_CH-1:0]      invert_i = '0;
  logic                   res16_i = 1'b0;
  logic                   left_align_i = 1'b0;
  logic                   conv_end_o;
  logic [31:0]            read_data_o;
  logic [2:0]             read_ch_o;
  logic [31:0]            xfer_word_o;

  int checks = 0;
  int fails = 0;
  int unsigned lcg = 32'h1234_5678;

  always #10 clk_i = ~clk_i;

  result_avg_fmt #(.NUM_CH(NUM_CH)) u_result_avg_fmt (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int unsigned nxt_rand();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg;
  endfunction

  task automatic set_cfg(input int code, input int mode, input bit r16, input bit lft);
    for (int c = 0; c < NUM_CH; c++) begin
      avg_sel_i[c]      = 3'(code);
      single_ended_i[c] = (mode != 0);
      neg_pol_i[c]      = (mode >= 2);
      invert_i[c]       = (mode == 3);
    end
    res16_i      = r16;
    left_align_i = lft;
  endtask

  // drive one sample at a negedge; outputs are sampled one clock later
  task automatic send(input int ch, input logic [23:0] d, input bit ovf);
    @(negedge clk_i);
    sample_valid_i = 1'b1;
    sample_ch_i    = 3'(ch);
    sample_data_i  = d;
    sample_ovf_i   = ovf;
    @(negedge clk_i);
    sample_valid_i = 1'b0;
  endtask

  task automatic run(input int ch, input int code, input int mode, input bit r16,
                     input bit lft, input int pat);
    int     n, k, ovf_idx;
    longint sum, avg, v, r, xexp;
    logic [23:0] d;
    bit     ovf_all;
    k = (code == 0) ? 0 : code + 2;
    n = 1 << k;
    sum = 0;
    ovf_all = 0;
    ovf_idx = (pat == 0) ? int'(nxt_rand() % 32'(n)) : -1;
    @(negedge clk_i);
    set_cfg(code, mode, r16, lft);
    for (int i = 0; i < n; i++) begin
      d = (pat == 1) ? ((mode == 0) ? 24'h7FFFFF : 24'hFFFFFF) :
          (pat == 2) ? ((mode == 0) ? 24'h800000 : 24'h000000) : 24'(nxt_rand() >> 4);
      sum += (mode == 0) ? longint'($signed(d)) : longint'(d);
      ovf_all |= (i == ovf_idx);
      send(ch, d, i == ovf_idx);
      chk(conv_end_o == (i == n - 1), "R2 strobe timing", conv_end_o, i == n - 1);
    end
    avg = (sum >>> k) & 64'hFF_FFFF;                                  // R9 floor average
    xexp = (longint'(ch + 1) << 25) | (longint'(ovf_all) << 24) | avg;
    chk(xfer_word_o == xexp, "R1 R3 R4 R9 R10 transfer word", xfer_word_o, xexp);
    v = (mode == 3) ? (64'hFF_FFFF - avg) : avg;                      // R7
    if (r16) v = v >> 8;                                              // R5
    r = lft ? (v << (r16 ? 16 : 8)) : v;                              // R6 R8
    chk(read_data_o == r, "R5 R6 R7 R8 read value", read_data_o, r);
    chk(read_ch_o == 3'(ch), "R3 read channel", read_ch_o, ch);
  endtask

  initial begin
    #50000000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int idx;
    #25;
    chk(conv_end_o == 0 && read_data_o == 0 && xfer_word_o == 0 && read_ch_o == 0,
        "R12 reset state", xfer_word_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(conv_end_o == 0 && xfer_word_o == 0, "R12 after release", xfer_word_o, 0);

    idx = 0;
    for (int pat = 0; pat < 3; pat++)
      for (int code = 0; code < 5; code++)
        for (int mode = 0; mode < 4; mode++)
          for (int fm = 0; fm < 4; fm++) begin
            run(idx % NUM_CH, code, mode, fm[0], fm[1], pat);
            idx++;
          end

    // R11: channel switch discards the partial sum
    @(negedge clk_i);
    set_cfg(1, 0, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      send(0, 24'h400000, 1'b1);
      chk(conv_end_o == 0, "R11 no strobe on partial", conv_end_o, 0);
    end
    for (int i = 0; i < 8; i++) begin
      send(1, 24'h000010 + 24'(i), 1'b0);
      chk(conv_end_o == (i == 7), "R11 strobe after switch", conv_end_o, i == 7);
    end
    chk(xfer_word_o == ((32'd2 << 25) | 32'h000013), "R11 switch average",
        xfer_word_o, (32'd2 << 25) | 32'h000013);

    // R11 R12: reset discards the partial sum
    for (int i = 0; i < 5; i++) send(2, 24'h700000, 1'b1);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #5;
    chk(conv_end_o == 0 && xfer_word_o == 0 && read_data_o == 0, "R12 mid-run reset",
        xfer_word_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < 8; i++) begin
      send(2, 24'h000100, 1'b0);
      chk(conv_end_o == (i == 7), "R11 strobe after reset", conv_end_o, i == 7);
    end
    chk(xfer_word_o == ((32'd3 << 25) | 32'h000100), "R11 R10 average after reset",
        xfer_word_o, (32'd3 << 25) | 32'h000100);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule